// File: doc/BRIEF.md
# Shift and Complement Unit

A purely combinational 32-bit datapath block for the single-source register operations of a small processor. It takes an operation code, one source word and a five-bit shift amount, and returns the result word together with a one-bit carry-out. There are five operations: left shift with zero fill, left rotate, right shift with zero fill, right shift with sign fill, and bitwise inversion.

The unit has no right-rotate operation. Software gets a right rotate by N by asking for a left rotate by (32 - N) mod 32. A shift amount of zero makes any shift a register copy. Inversion does not look at the amount. The register file, the writeback path and the condition flags all sit outside this block.

The block holds no state. It is built from two logarithmic barrel shifters, one for each direction, and a small carry selector. The output multiplexer picks the result using the operation code.

Top module: `shcmp_unit`

## Requirements
- R1: With `op_i` = 5'b10000, `res_o` equals `src_i` shifted left by `cnt_i` places, with zeros filling the low end.
- R2: With `op_i` = 5'b10001, `res_o` equals `src_i` rotated left by `cnt_i` places. Bits leaving bit 31 re-enter at bit 0.
- R3: For any of the four shift codes (5'b10000 to 5'b10011), a `cnt_i` of 0 gives `res_o` = `src_i` and `cout_o` = 0.
- R4: With `op_i` = 5'b10010, `res_o` equals `src_i` shifted right by `cnt_i` places, with zeros filling the high end.
- R5: With `op_i` = 5'b10011, `res_o` equals `src_i` shifted right by `cnt_i` places, with copies of `src_i[31]` filling the high end.
- R6: With `op_i` = 5'b10100, `res_o` equals `~src_i` for every value of `cnt_i`.
- R7: For left shifts, `cout_o` is `src_i[32-cnt_i]`. For both right shifts, `cout_o` is `src_i[cnt_i-1]`. These hold when `cnt_i` > 0. For the rotate and the inversion, `cout_o` is 0.
- R8: A zero `src_i` gives `res_o` = 0 and `cout_o` = 0 for every code except 5'b10100.
- R9: Any `op_i` outside 5'b10000 to 5'b10100 gives `res_o` = 0 and `cout_o` = 0.
- R10: A left rotate by (32 - N) mod 32 equals a right rotation of `src_i` by N, for N from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| src_i | input | 32 | Source operand |
| cnt_i | input | 5 | Unsigned shift amount, 0 to 31 |
| res_o | output | 32 | Result word |
| cout_o | output | 1 | Last bit shifted out |

## Verification
The checker assumes that all three inputs hold known values whenever it evaluates. While any input bit is X or Z it checks nothing, so the time before the bench first drives the inputs is skipped. The bench drives every input to a defined value right after reset. It changes the inputs only just after a rising clock edge and compares the outputs at the following falling edge, when the combinational paths have settled. The operation codes it uses cover the five defined ones, the codes next to them on either side, and random 5-bit values. These include codes the checker must see as undefined.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [4:0] {
        OP_SHL = 5'b10000,
        OP_ROL = 5'b10001,
        OP_SHR = 5'b10010,
        OP_SAR = 5'b10011,
        OP_INV = 5'b10100
    } sc_op_e;

    function automatic logic is_shift(input logic [4:0] op);
        return (op == OP_SHL) || (op == OP_ROL) || (op == OP_SHR) || (op == OP_SAR);
    endfunction
endpackage

// File: rtl/sc_barrel.sv
// Logarithmic shifter; LEFT selects direction, fill_ctrl picks rotate
// (left) or sign fill (right).
module sc_barrel #(
    parameter int  WIDTH = 32,
    parameter bit  LEFT  = 1'b1,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             fill_ctrl_i,
    output logic [WIDTH-1:0] data_o
);
    logic [CNT_W:0][WIDTH-1:0] stage;
    logic                      sign_fill;

    assign sign_fill = fill_ctrl_i & data_i[WIDTH-1];
    assign stage[0]  = data_i;

    for (genvar gk = 0; gk < CNT_W; gk++) begin : g_stage
        localparam int SH = 1 << gk;
        if (LEFT) begin : g_left
            logic [SH-1:0] low_fill;
            assign low_fill = fill_ctrl_i ? stage[gk][WIDTH-1:WIDTH-SH] : '0;
            assign stage[gk+1] = cnt_i[gk] ? {stage[gk][WIDTH-SH-1:0], low_fill}
                                           : stage[gk];
        end else begin : g_right
            assign stage[gk+1] = cnt_i[gk] ? {{SH{sign_fill}}, stage[gk][WIDTH-1:SH]}
                                           : stage[gk];
        end
    end

    assign data_o = stage[CNT_W];
endmodule

// File: rtl/sc_carry.sv
// Selects the last bit pushed out of the word by a non-rotating shift.
module sc_carry #(
    parameter int  WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cout_o
);
    import sc_pkg::*;

    localparam logic [CNT_W:0] W_EXT = (CNT_W+1)'(WIDTH);

    logic [CNT_W:0]   left_idx_ext;
    logic [CNT_W-1:0] left_idx;
    logic [CNT_W-1:0] right_idx;

    assign left_idx_ext = W_EXT - {1'b0, cnt_i};
    assign left_idx     = left_idx_ext[CNT_W-1:0];
    assign right_idx    = cnt_i - CNT_W'(1);

    always_comb begin
        cout_o = 1'b0;
        if (cnt_i != '0) begin
            case (op_i)
                OP_SHL:         cout_o = src_i[left_idx];
                OP_SHR, OP_SAR: cout_o = src_i[right_idx];
                default:        cout_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/shcmp_unit.sv
module shcmp_unit #(
    parameter int  WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    import sc_pkg::*;

    logic [WIDTH-1:0] left_res;
    logic [WIDTH-1:0] right_res;
    logic             rotate_en;
    logic             arith_en;
    logic             carry_raw;

    assign rotate_en = (op_i == OP_ROL);
    assign arith_en  = (op_i == OP_SAR);

    sc_barrel #(.WIDTH(WIDTH), .LEFT(1'b1)) u_left (
        .data_i      (src_i),
        .cnt_i       (cnt_i),
        .fill_ctrl_i (rotate_en),
        .data_o      (left_res)
    );

    sc_barrel #(.WIDTH(WIDTH), .LEFT(1'b0)) u_right (
        .data_i      (src_i),
        .cnt_i       (cnt_i),
        .fill_ctrl_i (arith_en),
        .data_o      (right_res)
    );

    sc_carry #(.WIDTH(WIDTH)) u_carry (
        .op_i   (op_i),
        .src_i  (src_i),
        .cnt_i  (cnt_i),
        .cout_o (carry_raw)
    );

    always_comb begin
        case (op_i)
            OP_SHL, OP_ROL: res_o = left_res;
            OP_SHR, OP_SAR: res_o = right_res;
            OP_INV:         res_o = ~src_i;
            default:        res_o = '0;
        endcase
    end

    assign cout_o = carry_raw;
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int  WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input logic [4:0]       op_i,
    input logic [WIDTH-1:0] src_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [WIDTH-1:0] res_o,
    input logic             cout_o
);
    import sc_pkg::*;

    logic known;
    logic defined_op;
    assign known      = !$isunknown({op_i, src_i, cnt_i});
    assign defined_op = (op_i >= 5'b10000) && (op_i <= 5'b10100);

    always_comb begin
        if (known) begin
            if (is_shift(op_i) && cnt_i == '0)
                p_move_on_zero_r3: assert (res_o == src_i && !cout_o);
            if (op_i == OP_INV)
                p_invert_r6: assert (res_o == ~src_i);
            if (op_i == OP_ROL || op_i == OP_INV)
                p_no_carry_r7: assert (!cout_o);
            if (src_i == '0 && op_i != OP_INV)
                p_clear_on_zero_r8: assert (res_o == '0 && !cout_o);
            if (!defined_op)
                p_undefined_zero_r9: assert (res_o == '0 && !cout_o);
        end
    end
endmodule

bind shcmp_unit sc_checker #(.WIDTH(WIDTH)) u_sc_checker (
    .op_i   (op_i),
    .src_i  (src_i),
    .cnt_i  (cnt_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/shcmp_unit_tb_top.sv
`timescale 1ns/1ps
module shcmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op;
    logic [31:0] src;
    logic [4:0]  cnt;
    logic [31:0] res;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shcmp_unit dut_i (
        .op_i   (op),
        .src_i  (src),
        .cnt_i  (cnt),
        .res_o  (res),
        .cout_o (cout)
    );

    // Behavioural model: one bit moved per step.
    task automatic model(input logic [4:0] o, input logic [31:0] s, input int n,
                         output logic [31:0] r, output logic c);
        r = s;
        c = 1'b0;
        case (o)
            5'b10000: for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
            5'b10001: for (int i = 0; i < n; i++) r = {r[30:0], r[31]};
            5'b10010: for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[31:1]}; end
            5'b10011: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
            5'b10100: r = ~s;
            default:  r = '0;
        endcase
    endtask

    task automatic compare(input string tag, input logic [31:0] er, input logic ec);
        checks++;
        if (res !== er || cout !== ec) begin
            errors++;
            $display("FAIL %s: op=%b src=%h cnt=%0d got res=%h cout=%b expected res=%h cout=%b",
                     tag, op, src, cnt, res, cout, er, ec);
        end
    endtask

    task automatic apply(input string tag, input logic [4:0] o, input logic [31:0] s,
                         input logic [4:0] n);
        logic [31:0] er;
        logic        ec;
        @(posedge clk);
        #1;
        op = o; src = s; cnt = n;
        model(o, s, int'(n), er, ec);
        @(negedge clk);
        compare(tag, er, ec);
    endtask

    task automatic rotr_check(input logic [31:0] s, input int n);
        logic [31:0] er;
        er = (n == 0) ? s : ((s >> n) | (s << (32 - n)));
        @(posedge clk);
        #1;
        op = 5'b10001; src = s; cnt = 5'((32 - n) % 32);
        @(negedge clk);
        compare("R10", er, 1'b0);
    endtask

    initial begin
        op = '0; src = '0; cnt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("reset R9", 32'h0, 1'b0);

        apply("R1", 5'b10000, 32'h8000_0001, 5'd1);
        apply("R1", 5'b10000, 32'h1234_5678, 5'd31);
        apply("R2", 5'b10001, 32'h8000_0001, 5'd1);
        apply("R2", 5'b10001, 32'hF000_000F, 5'd4);
        apply("R3", 5'b10000, 32'hDEAD_BEEF, 5'd0);
        apply("R3", 5'b10011, 32'h8000_0000, 5'd0);
        apply("R4", 5'b10010, 32'h8000_0001, 5'd31);
        apply("R4", 5'b10010, 32'hFFFF_FFFF, 5'd8);
        apply("R5", 5'b10011, 32'h8000_0000, 5'd31);
        apply("R5", 5'b10011, 32'h7FFF_FFFF, 5'd4);
        apply("R6", 5'b10100, 32'h0F0F_0F0F, 5'd17);
        apply("R6", 5'b10100, 32'h0000_0000, 5'd0);
        apply("R7", 5'b10000, 32'h0800_0000, 5'd5);
        apply("R7", 5'b10010, 32'h0000_0010, 5'd5);
        apply("R7", 5'b10011, 32'h0000_0001, 5'd1);
        for (int o = 16; o < 20; o++) apply("R8", 5'(o), 32'h0, 5'd13);
        apply("R9", 5'b10101, 32'hFFFF_FFFF, 5'd3);
        apply("R9", 5'b01111, 32'hFFFF_FFFF, 5'd3);
        apply("R9", 5'b11111, 32'h1234_5678, 5'd0);
        for (int n = 0; n < 32; n++) rotr_check(32'hA5C3_0F81, n);

        for (int i = 0; i < 3000; i++) begin
            logic [4:0] ro;
            ro = (i % 4 == 0) ? 5'($urandom) : 5'(16 + ($urandom % 5));
            apply("R1 R2 R4 R5 R6 R7 R9 random", ro, 32'($urandom), 5'($urandom));
        end
        for (int i = 0; i < 200; i++) rotr_check(32'($urandom), int'($urandom % 32));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule